// File: doc/BRIEF.md
# Integer Subtract, Extend and Test Execute Unit

This block is the integer execute stage for a small group of 16-bit instructions. It holds sixteen general registers, each `XLEN` bits wide, and a single status flag T. Each instruction word that arrives with its valid strobe is decoded and executed in one clock. The register named in bits 11:8 (n) receives the result. Bits 7:4 (m) name the source register.

The operations are:
- decrement with a zero test;
- sign extension and zero extension of the low byte or low halfword;
- negation, plain and with borrow;
- subtraction, plain, with borrow, and with signed-overflow detection.

T takes a different meaning depending on the operation: a zero test, a borrow, or an overflow. Operations that do not define T leave it untouched.

After each clock edge that executes an instruction, the unit presents one cycle of register-write information: the enable, the index and the data. A software model or a later pipeline stage can follow the register file from this alone. A word that matches none of the supported encodings raises a one-cycle illegal indication and has no other effect.

Top module: `intx_exec`

## Requirements
- R1: After reset, all sixteen registers and T read as zero, and `wr_en` and `illegal` are low.
- R2: Word `0100 nnnn 0001 0000` writes Rn-1 to Rn. It sets T to 1 if that result is zero and clears T otherwise.
- R3: Words `0110 nnnn mmmm 1110` and `0110 nnnn mmmm 1111` write to Rn the low 8 bits and the low 16 bits of Rm, respectively, sign-extended. T is unchanged.
- R4: Words `0110 nnnn mmmm 1100` and `0110 nnnn mmmm 1101` write to Rn the low 8 bits and the low 16 bits of Rm, respectively, zero-extended. T is unchanged.
- R5: Word `0110 nnnn mmmm 1011` writes 0-Rm to Rn. T is unchanged.
- R6: Word `0110 nnnn mmmm 1010` writes 0-Rm-T to Rn. T receives the unsigned borrow out of that subtraction.
- R7: Word `0011 nnnn mmmm 1000` writes Rn-Rm to Rn. T is unchanged.
- R8: Word `0011 nnnn mmmm 1010` writes Rn-Rm-T to Rn. T receives the unsigned borrow.
- R9: Word `0011 nnnn mmmm 1011` writes Rn-Rm to Rn. T is set when the two's-complement result overflows and cleared otherwise.
- R10: Any other word presented with `instr_valid` high gives `illegal` high for the following cycle, `wr_en` low, and no change to any register or to T.
- R11: While `instr_valid` is low, the instruction word is ignored: no register or T change, and `wr_en` and `illegal` stay low.
- R12: When n equals m, the operation uses the value the register held before the instruction.
- R13: Every instruction completes in one clock. `wr_en`, `wr_idx`, `wr_data` and the new T appear in the cycle after the executing edge. Back-to-back dependent instructions see each other's results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 16 | Instruction word |
| wr_en | output | 1 | One-cycle pulse: a register was written by the last instruction |
| wr_idx | output | 4 | Index of the register written |
| wr_data | output | XLEN | Value written |
| t_flag | output | 1 | Current T flag |
| illegal | output | 1 | One-cycle pulse: the last valid word was not a supported encoding |

## Verification
The bench builds the unit with `XLEN` = 32 and the default single-subtractor variant. At this width the sign bit sits at bit 31, so the overflow cases at 0x80000000 and 0x7FFFFFFF and the borrow from 0xFFFFFFFF all occur. The bench builds arbitrary register values using only the supported operations, by repeated double-and-increment. This exercises every encoding, and both values of T on entry, against full-width operands. `SUB_IMPL` = 1 swaps in the variant that derives borrow from the sign bits; the same vector table applies to it unchanged.

// File: rtl/intx_pkg.sv
`timescale 1ns/1ps
package intx_pkg;

   typedef enum logic [3:0] {
      OP_NONE    = 4'd0,
      OP_DEC_TST = 4'd1,
      OP_SXB     = 4'd2,
      OP_SXH     = 4'd3,
      OP_ZXB     = 4'd4,
      OP_ZXH     = 4'd5,
      OP_NEG     = 4'd6,
      OP_NEG_B   = 4'd7,
      OP_SUB     = 4'd8,
      OP_SUB_B   = 4'd9,
      OP_SUB_V   = 4'd10
   } op_e;

   typedef struct packed {
      op_e        op;
      logic [3:0] rn;
      logic [3:0] rm;
      logic       legal;
      logic       upd_t;
   } dec_s;

   localparam int RIDX_W = 4;
   localparam int NREG   = 2 ** RIDX_W;

endpackage

// File: rtl/intx_decode.sv
`timescale 1ns/1ps
module intx_decode
   import intx_pkg::*;
(
   input  logic [15:0] iw,
   output dec_s        d
);

   logic [3:0] grp;
   logic [3:0] sub;

   assign grp = iw[15:12];
   assign sub = iw[3:0];

   always_comb begin
      d       = '0;
      d.op    = OP_NONE;
      d.rn    = iw[11:8];
      d.rm    = iw[7:4];
      unique case (grp)
         4'h4: begin
            if (iw[7:0] == 8'h10) d.op = OP_DEC_TST;
         end
         4'h6: begin
            unique case (sub)
               4'hE:    d.op = OP_SXB;
               4'hF:    d.op = OP_SXH;
               4'hC:    d.op = OP_ZXB;
               4'hD:    d.op = OP_ZXH;
               4'hB:    d.op = OP_NEG;
               4'hA:    d.op = OP_NEG_B;
               default: d.op = OP_NONE;
            endcase
         end
         4'h3: begin
            unique case (sub)
               4'h8:    d.op = OP_SUB;
               4'hA:    d.op = OP_SUB_B;
               4'hB:    d.op = OP_SUB_V;
               default: d.op = OP_NONE;
            endcase
         end
         default: d.op = OP_NONE;
      endcase
      d.legal = (d.op != OP_NONE);
      d.upd_t = (d.op == OP_DEC_TST) || (d.op == OP_NEG_B) ||
                (d.op == OP_SUB_B)   || (d.op == OP_SUB_V);
   end

endmodule

// File: rtl/intx_sub.sv
`timescale 1ns/1ps
module intx_sub #(
   parameter int XLEN = 32,
   parameter int IMPL = 0
) (
   input  logic [XLEN-1:0] x,
   input  logic [XLEN-1:0] y,
   input  logic            cin,
   output logic [XLEN-1:0] diff,
   output logic            borrow,
   output logic            ovf
);

   localparam int MSB = XLEN - 1;

   generate
      if (IMPL == 0) begin : g_wide
         logic [XLEN:0] ext;
         assign ext    = {1'b0, x} - {1'b0, y} - {{XLEN{1'b0}}, cin};
         assign diff   = ext[XLEN-1:0];
         assign borrow = ext[XLEN];
      end else begin : g_msb
         assign diff   = x + ~y + {{(XLEN-1){1'b0}}, ~cin};
         assign borrow = (~x[MSB] & y[MSB]) | (~(x[MSB] ^ y[MSB]) & diff[MSB]);
      end
   endgenerate

   assign ovf = (x[MSB] ^ y[MSB]) & (x[MSB] ^ diff[MSB]);

   always_comb begin
      p_ovf_sign_r9: assert (!ovf || (x[MSB] != y[MSB]));
   end

endmodule

// File: rtl/intx_alu.sv
`timescale 1ns/1ps
module intx_alu
   import intx_pkg::*;
#(
   parameter int XLEN     = 32,
   parameter int SUB_IMPL = 0
) (
   input  op_e             op,
   input  logic [XLEN-1:0] rn_val,
   input  logic [XLEN-1:0] rm_val,
   input  logic            t_in,
   output logic [XLEN-1:0] res,
   output logic            t_out
);

   localparam logic [XLEN-1:0] ONE  = {{(XLEN-1){1'b0}}, 1'b1};
   localparam logic [XLEN-1:0] ZERO = '0;

   logic [XLEN-1:0] sx, sy, sdiff;
   logic            scin, sbor, sovf;

   always_comb begin
      sx   = rn_val;
      sy   = rm_val;
      scin = 1'b0;
      unique case (op)
         OP_DEC_TST: sy = ONE;
         OP_NEG:     sx = ZERO;
         OP_NEG_B: begin
            sx   = ZERO;
            scin = t_in;
         end
         OP_SUB_B:   scin = t_in;
         default: ;
      endcase
   end

   intx_sub #(.XLEN(XLEN), .IMPL(SUB_IMPL)) u_sub (
      .x      (sx),
      .y      (sy),
      .cin    (scin),
      .diff   (sdiff),
      .borrow (sbor),
      .ovf    (sovf)
   );

   always_comb begin
      unique case (op)
         OP_SXB:  res = {{(XLEN-8){rm_val[7]}}, rm_val[7:0]};
         OP_SXH:  res = {{(XLEN-16){rm_val[15]}}, rm_val[15:0]};
         OP_ZXB:  res = {{(XLEN-8){1'b0}}, rm_val[7:0]};
         OP_ZXH:  res = {{(XLEN-16){1'b0}}, rm_val[15:0]};
         default: res = sdiff;
      endcase
   end

   always_comb begin
      unique case (op)
         OP_DEC_TST:         t_out = (sdiff == ZERO);
         OP_NEG_B, OP_SUB_B: t_out = sbor;
         OP_SUB_V:           t_out = sovf;
         default:            t_out = t_in;
      endcase
   end

   always_comb begin
      if (op == OP_ZXB) p_zx_upper_r4: assert (res[XLEN-1:8] == '0);
      if (op == OP_SXB) p_sx_fill_r3: assert ((&res[XLEN-1:7]) || !(|res[XLEN-1:7]));
   end

endmodule

// File: rtl/intx_regfile.sv
`timescale 1ns/1ps
module intx_regfile
   import intx_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [RIDX_W-1:0] waddr,
   input  logic [XLEN-1:0]   wdata,
   input  logic [RIDX_W-1:0] ra_n,
   input  logic [RIDX_W-1:0] ra_m,
   output logic [XLEN-1:0]   rd_n,
   output logic [XLEN-1:0]   rd_m
);

   logic [XLEN-1:0] mem [NREG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) mem[i] <= '0;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rd_n = mem[ra_n];
   assign rd_m = mem[ra_m];

   p_wr_lands_r13: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (mem[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/intx_exec.sv
`timescale 1ns/1ps
module intx_exec
   import intx_pkg::*;
#(
   parameter int XLEN     = 32,
   parameter int SUB_IMPL = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            instr_valid,
   input  logic [15:0]     instr,
   output logic            wr_en,
   output logic [3:0]      wr_idx,
   output logic [XLEN-1:0] wr_data,
   output logic            t_flag,
   output logic            illegal
);

   generate
      if (XLEN < 16) begin : g_bad_xlen
         $error("intx_exec: XLEN must be at least 16");
      end
      if (SUB_IMPL < 0 || SUB_IMPL > 1) begin : g_bad_impl
         $error("intx_exec: SUB_IMPL must be 0 or 1");
      end
   endgenerate

   dec_s            dec;
   logic [XLEN-1:0] rn_val, rm_val, alu_res;
   logic            t_next, fire, bad;

   intx_decode u_dec (.iw(instr), .d(dec));

   assign fire = instr_valid && dec.legal;
   assign bad  = instr_valid && !dec.legal;

   intx_regfile #(.XLEN(XLEN)) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (fire),
      .waddr (dec.rn),
      .wdata (alu_res),
      .ra_n  (dec.rn),
      .ra_m  (dec.rm),
      .rd_n  (rn_val),
      .rd_m  (rm_val)
   );

   intx_alu #(.XLEN(XLEN), .SUB_IMPL(SUB_IMPL)) u_alu (
      .op     (dec.op),
      .rn_val (rn_val),
      .rm_val (rm_val),
      .t_in   (t_flag),
      .res    (alu_res),
      .t_out  (t_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         t_flag  <= 1'b0;
         wr_en   <= 1'b0;
         wr_idx  <= '0;
         wr_data <= '0;
         illegal <= 1'b0;
      end else begin
         wr_en   <= fire;
         illegal <= bad;
         if (fire) begin
            wr_idx  <= dec.rn;
            wr_data <= alu_res;
            if (dec.upd_t) t_flag <= t_next;
         end
      end
   end

   // R10: an illegal pulse never coincides with a write
   p_ill_nowr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> !wr_en);

   // R5, R7, R10, R11: T moves only for flag-defining operations
   p_t_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(instr_valid && dec.legal && dec.upd_t) |=> $stable(t_flag));

   p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_valid |=> (!wr_en && !illegal));

   p_one_cycle_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && dec.legal) |=> (wr_en && !illegal));

   p_dt_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && dec.op == OP_DEC_TST) |=> (t_flag == (wr_data == '0)));

endmodule

// File: tb/tb_intx_exec.sv
`timescale 1ns/1ps
module tb_intx_exec;

   localparam int XLEN = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            instr_valid = 1'b0;
   logic [15:0]     instr = 16'h0000;
   logic            wr_en, t_flag, illegal;
   logic [3:0]      wr_idx;
   logic [XLEN-1:0] wr_data;

   int total = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   intx_exec #(.XLEN(XLEN), .SUB_IMPL(0)) dut (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .t_flag(t_flag), .illegal(illegal)
   );

   typedef struct packed {
      logic [15:0] iw;
      logic [31:0] a;
      logic [31:0] b;
      logic        ti;
      logic [31:0] er;
      logic        et;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VEC [NV] = '{
      '{16'h4110, 32'h00000001, 32'h0,        1'b0, 32'h00000000, 1'b1},
      '{16'h4110, 32'h00000000, 32'h0,        1'b1, 32'hFFFFFFFF, 1'b0},
      '{16'h4110, 32'h00000005, 32'h0,        1'b1, 32'h00000004, 1'b0},
      '{16'h612E, 32'h0,        32'h00000080, 1'b1, 32'hFFFFFF80, 1'b1},
      '{16'h612E, 32'h0,        32'h1234567F, 1'b0, 32'h0000007F, 1'b0},
      '{16'h612F, 32'h0,        32'h00018000, 1'b0, 32'hFFFF8000, 1'b0},
      '{16'h612C, 32'h0,        32'hFFFFFF80, 1'b1, 32'h00000080, 1'b1},
      '{16'h612D, 32'h0,        32'hFFFF8001, 1'b0, 32'h00008001, 1'b0},
      '{16'h612B, 32'h0,        32'h00000001, 1'b1, 32'hFFFFFFFF, 1'b1},
      '{16'h612B, 32'h0,        32'h80000000, 1'b0, 32'h80000000, 1'b0},
      '{16'h612A, 32'h0,        32'h00000000, 1'b0, 32'h00000000, 1'b0},
      '{16'h612A, 32'h0,        32'h00000000, 1'b1, 32'hFFFFFFFF, 1'b1},
      '{16'h612A, 32'h0,        32'h00000001, 1'b0, 32'hFFFFFFFF, 1'b1},
      '{16'h3128, 32'h0000000A, 32'h00000003, 1'b1, 32'h00000007, 1'b1},
      '{16'h312A, 32'h00000005, 32'h00000005, 1'b1, 32'hFFFFFFFF, 1'b1},
      '{16'h312A, 32'h00000007, 32'h00000002, 1'b1, 32'h00000004, 1'b0},
      '{16'h312A, 32'h00000000, 32'hFFFFFFFF, 1'b0, 32'h00000001, 1'b1},
      '{16'h312B, 32'h80000000, 32'h00000001, 1'b0, 32'h7FFFFFFF, 1'b1},
      '{16'h312B, 32'h7FFFFFFF, 32'hFFFFFFFF, 1'b0, 32'h80000000, 1'b1},
      '{16'h312B, 32'h00000005, 32'h00000003, 1'b1, 32'h00000002, 1'b0}
   };

   function automatic string req_of(input logic [15:0] w);
      if (w[15:12] == 4'h4) return "R2";
      if (w[15:12] == 4'h6) begin
         case (w[3:0])
            4'hE, 4'hF: return "R3";
            4'hC, 4'hD: return "R4";
            4'hB:       return "R5";
            default:    return "R6";
         endcase
      end
      case (w[3:0])
         4'h8:    return "R7";
         4'hA:    return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   endtask

   // one instruction: driven after an edge, executed on the next edge, sampled 2 ns later
   task automatic exec(input logic [15:0] w);
      instr_valid = 1'b1;
      instr       = w;
      @(posedge clk);
      #2;
      instr_valid = 1'b0;
   endtask

   // builds v in register r from sub/neg only; needs R13 = -1, uses R12
   task automatic load_const(input logic [3:0] r, input logic [31:0] v);
      exec({4'h3, r, r, 4'h8});
      for (int i = 31; i >= 0; i--) begin
         exec({4'h6, 4'd12, r, 4'hB});
         exec({4'h3, r, 4'd12, 4'h8});
         if (v[i]) exec({4'h3, r, 4'd13, 4'h8});
      end
      chk("R13 dependent chain", wr_data, v);
   endtask

   task automatic set_t(input logic b);
      load_const(4'd14, {31'd0, b});
      exec({4'h4, 4'd14, 8'h10});
   endtask

   // observes a full register through negation into R12
   task automatic read_reg(input logic [3:0] r, output logic [31:0] v);
      exec({4'h6, 4'd12, r, 4'hB});
      v = -wr_data;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

   initial begin
      logic [31:0] rv;
      repeat (3) @(posedge clk);
      #2;
      chk("R1 t_flag in reset", {31'd0, t_flag}, 32'd0);
      chk("R1 wr_en in reset", {31'd0, wr_en}, 32'd0);
      chk("R1 illegal in reset", {31'd0, illegal}, 32'd0);
      rst_n = 1'b1;
      @(posedge clk);
      #2;
      read_reg(4'd4, rv);
      chk("R1 register cleared", rv, 32'd0);
      chk("R1 T cleared", {31'd0, t_flag}, 32'd0);
      read_reg(4'd9, rv);
      chk("R1 register cleared", rv, 32'd0);

      exec({4'h4, 4'd13, 8'h10});
      chk("R2 dec from zero", wr_data, 32'hFFFFFFFF);

      // vector table
      for (int k = 0; k < NV; k++) begin
         load_const(4'd1, VEC[k].a);
         load_const(4'd2, VEC[k].b);
         set_t(VEC[k].ti);
         exec(VEC[k].iw);
         chk({req_of(VEC[k].iw), " result"}, wr_data, VEC[k].er);
         chk({req_of(VEC[k].iw), " T"}, {31'd0, t_flag}, {31'd0, VEC[k].et});
         chk({req_of(VEC[k].iw), " write index"}, {28'd0, wr_idx}, 32'd1);
      end

      // R10: illegal words
      load_const(4'd5, 32'hCAFE0001);
      set_t(1'b1);
      exec(16'h6529);
      chk("R10 illegal flag", {31'd0, illegal}, 32'd1);
      chk("R10 no write", {31'd0, wr_en}, 32'd0);
      exec(16'h4511);
      chk("R10 illegal flag near DT", {31'd0, illegal}, 32'd1);
      exec(16'h3529);
      chk("R10 illegal flag grp3", {31'd0, illegal}, 32'd1);
      exec(16'hFFFF);
      chk("R10 illegal flag all ones", {31'd0, illegal}, 32'd1);
      chk("R10 T unchanged", {31'd0, t_flag}, 32'd1);
      read_reg(4'd5, rv);
      chk("R10 illegal pulse drops", {31'd0, illegal}, 32'd0);
      chk("R10 register unchanged", rv, 32'hCAFE0001);

      // R11: valid low
      instr = {4'h4, 4'd5, 8'h10};
      instr_valid = 1'b0;
      @(posedge clk);
      #2;
      chk("R11 no write when idle", {31'd0, wr_en}, 32'd0);
      chk("R11 no illegal when idle", {31'd0, illegal}, 32'd0);
      instr = 16'hFFFF;
      @(posedge clk);
      #2;
      chk("R11 illegal word ignored when idle", {31'd0, illegal}, 32'd0);
      chk("R11 T unchanged", {31'd0, t_flag}, 32'd1);
      read_reg(4'd5, rv);
      chk("R11 register unchanged", rv, 32'hCAFE0001);

      // R12: n equals m
      load_const(4'd6, 32'h00001234);
      exec(16'h3668);
      chk("R12 sub self", wr_data, 32'd0);
      load_const(4'd6, 32'd5);
      set_t(1'b1);
      exec(16'h366A);
      chk("R12 subc self", wr_data, 32'hFFFFFFFF);
      chk("R12 subc self T", {31'd0, t_flag}, 32'd1);
      exec(16'h666B);
      chk("R12 neg self", wr_data, 32'd1);
      exec(16'h666E);
      chk("R12 sign-extend self", wr_data, 32'd1);

      // R13: back-to-back decrements
      load_const(4'd7, 32'd2);
      exec(16'h4710);
      chk("R13 first dec", wr_data, 32'd1);
      chk("R13 first dec T", {31'd0, t_flag}, 32'd0);
      exec(16'h4710);
      chk("R13 second dec", wr_data, 32'd0);
      chk("R13 second dec T", {31'd0, t_flag}, 32'd1);
      exec(16'h4710);
      chk("R13 third dec", wr_data, 32'hFFFFFFFF);
      chk("R13 third dec T", {31'd0, t_flag}, 32'd0);
      chk("R13 write index", {28'd0, wr_idx}, 32'd7);
      @(posedge clk);
      #2;
      chk("R13 write pulse ends", {31'd0, wr_en}, 32'd0);

      finish_up();
   end

endmodule